// File: doc/BRIEF.md
# PATA PIO bus cycle engine

This block runs single register reads and writes from a simple host-side request port as parallel ATA programmed-I/O cycles. The host presents an address, a size flag (byte or word), write data and a one-clock request. The block then produces one bus cycle on the device side with the right chip select, register address and read or write strobe. It watches the device's ready line and finishes with a one-clock done pulse. Read data is returned on the host read bus and stays there until the next read.

Three programmable counts set the cycle timing: a strobe setup, a strobe pulse and a total cycle length, all in clock cycles. The hardware adjusts these counts before use. It adds one setup cycle to absorb ringing. It stretches the cycle so that at least two recovery cycles follow the strobe. It places the chip-select window one cycle inside each end of the cycle. Host address bit 4 picks the command block or the control block. Bits 3 to 1 form the device register number, so every byte register sits on the low data lane.

Top module: `pata_pio_engine`

## Requirements
- R1: The strobe of an accepted request goes low at cycle offset S = setup + 1 and stays low for P cycles. Offset 0 is the first clock after the request is accepted. P is the programmed pulse count.
- R2: The bus cycle lasts C = max(cycle, S + P + 2) clocks. host_done is high only at offset C - 1, and at that offset chip selects and strobes are all inactive.
- R3: The selected chip select is low exactly for offsets 1 through C - 2. That is C - 2 clocks, and it covers the whole strobe.
- R4: A write uses the same S, P and C as a read, pulses the write strobe instead of the read strobe, and enables the data drivers (ata_dd_oe = 1) only for offsets 0 to S + P - 1. Outside those offsets, and for every read, the data bus is floated.
- R5: Read data is sampled in the last clock of the read strobe, just before the strobe rises. host_rdata holds that value until the next read captures a new one.
- R6: When host_addr[4] = 0, the cycle drives ata_cs0_n low and keeps ata_cs1_n high. When host_addr[4] = 1, the cycle drives ata_cs1_n low and keeps ata_cs0_n high. ata_da equals host_addr[3:1]. host_addr[0] has no effect.
- R7: A word access (host_word = 1) uses all 16 data bits only when host_addr[4:1] = 0, the data register. Any other access is a byte access: write data drives 0 on bits [15:8], and read data returns 0 in bits [15:8].
- R8: While ata_iordy is low during the strobe pulse, the pulse is held. Each clock of low ready adds one clock to the pulse and to the whole cycle.
- R9: After reset the counts are setup 4, pulse 15 and cycle 30. These are the PIO mode 0 figures (70 ns, 290 ns, 600 ns) at a 20 ns clock. An access therefore starts its strobe at offset 5, holds it for 15 clocks and lasts 30 clocks.
- R10: A timing write (cfg_we) takes effect only when no cycle is in progress and host_req is low. A host_req raised during a cycle is ignored and starts no cycle.
- R11: During and after reset, with no cycle running, both chip selects and both strobes are high, ata_dd_oe is low, host_done is low and host_rdata is 0.
- R12: A programmed pulse count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the three timing counts |
| cfg_setup | input | 8 | Strobe setup count, before the +1 adjustment |
| cfg_pulse | input | 8 | Strobe pulse count |
| cfg_cycle | input | 8 | Requested total cycle length |
| host_req | input | 1 | One-clock access request, taken when idle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Bit 4 bank select, bits 3:1 register, bit 0 unused |
| host_word | input | 1 | 1 = 16-bit access (data register only) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Last captured read data |
| host_done | output | 1 | One-clock pulse at the end of recovery |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data to the pad drivers |
| ata_dd_oe | output | 1 | Pad driver enable for the data bus |
| ata_dd_in | input | 16 | Data from the pads |
| ata_iordy | input | 1 | Device ready; low stretches the pulse |

## Verification
The properties make no assumption about ata_iordy. They only expect that a low ready seen during a strobe keeps that strobe low in the next clock. They rely on the fact that the adjusted counts always leave at least one clock of setup and two of recovery, so the chip-select window encloses the strobe for any programmed values. The stimulus issues one request at a time and waits an extra clock after each done. It pulls ready low only for short bounded spans inside a pulse. It also supplies device read data that depends only on the presented register address, so the data is stable across each strobe.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    localparam int DATA_W   = 16;
    localparam int REG_A_W  = 3;
    localparam int HOST_A_W = 5;
    localparam int BANK_BIT = HOST_A_W - 1;
    localparam int LANE_W   = 8;

    // One latched access, as seen on the device side
    typedef struct packed {
        logic               write;
        logic               alt;
        logic [REG_A_W-1:0] reg_a;
        logic               word;
        logic [DATA_W-1:0]  wdata;
    } pio_xfer_t;

    // Nanoseconds to whole clock cycles, rounding up
    function automatic int ns_to_cycles(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pata_pio_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DEF_SETUP = 4,
    parameter int DEF_PULSE = 15,
    parameter int DEF_CYCLE = 30,
    localparam int T_W      = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_ok,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_pulse,
    input  logic [CNT_W-1:0] cfg_cycle,
    output logic [T_W-1:0]   eff_setup,
    output logic [T_W-1:0]   eff_active,
    output logic [T_W-1:0]   eff_cycle
);

    logic [CNT_W-1:0] setup_q, pulse_q, cycle_q;
    logic [T_W-1:0]   pulse_w, floor_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= CNT_W'(DEF_SETUP);
            pulse_q <= CNT_W'(DEF_PULSE);
            cycle_q <= CNT_W'(DEF_CYCLE);
        end else if (cfg_we && cfg_ok) begin
            setup_q <= cfg_setup;
            pulse_q <= cfg_pulse;
            cycle_q <= cfg_cycle;
        end
    end

    // Ringing margin, minimum pulse, minimum recovery
    always_comb begin
        eff_setup  = T_W'(setup_q) + T_W'(1);
        pulse_w    = (pulse_q == '0) ? T_W'(1) : T_W'(pulse_q);
        eff_active = eff_setup + pulse_w;
        floor_w    = eff_active + T_W'(2);
        eff_cycle  = (T_W'(cycle_q) < floor_w) ? floor_w : T_W'(cycle_q);
    end

endmodule

// File: rtl/pio_addr_map.sv
module pio_addr_map
    import pata_pio_pkg::*;
(
    input  logic                host_write,
    input  logic [HOST_A_W-1:1] host_addr_hi,
    input  logic                host_word,
    input  logic [DATA_W-1:0]   host_wdata,
    output pio_xfer_t           xfer
);

    logic is_data_reg;

    always_comb begin
        xfer.write  = host_write;
        xfer.alt    = host_addr_hi[BANK_BIT];
        xfer.reg_a  = host_addr_hi[REG_A_W:1];
        is_data_reg = !xfer.alt && (xfer.reg_a == '0);
        xfer.word   = host_word && is_data_reg;
        xfer.wdata  = xfer.word ? host_wdata
                                : {{(DATA_W-LANE_W){1'b0}}, host_wdata[LANE_W-1:0]};
    end

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pata_pio_pkg::*;
#(
    parameter int T_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  pio_xfer_t          xfer,
    input  logic [T_W-1:0]     eff_setup,
    input  logic [T_W-1:0]     eff_active,
    input  logic [T_W-1:0]     eff_cycle,
    input  logic               iordy,
    input  logic [DATA_W-1:0]  dd_in,
    output logic               idle,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               cs0_n,
    output logic               cs1_n,
    output logic [REG_A_W-1:0] da,
    output logic               dior_n,
    output logic               diow_n,
    output logic [DATA_W-1:0]  dd_out,
    output logic               dd_oe
);

    logic              busy_q;
    logic [T_W-1:0]    t_q, s_q, a_q, c_q;
    pio_xfer_t         x_q;
    logic [DATA_W-1:0] rdata_q;
    logic              in_pulse, last, stall, cs_on;

    assign in_pulse = busy_q && (t_q >= s_q) && (t_q < a_q);
    assign last     = busy_q && (t_q == c_q - T_W'(1));
    assign stall    = in_pulse && !iordy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            t_q     <= '0;
            s_q     <= '0;
            a_q     <= '0;
            c_q     <= '0;
            x_q     <= '0;
            rdata_q <= '0;
        end else begin
            if (!busy_q) begin
                if (req) begin
                    busy_q <= 1'b1;
                    t_q    <= '0;
                    s_q    <= eff_setup;
                    a_q    <= eff_active;
                    c_q    <= eff_cycle;
                    x_q    <= xfer;
                end
            end else if (last) begin
                busy_q <= 1'b0;
            end else if (!stall) begin
                t_q <= t_q + T_W'(1);
            end
            // sample just before the read strobe rises
            if (in_pulse && iordy && !x_q.write && (t_q == a_q - T_W'(1)))
                rdata_q <= x_q.word ? dd_in
                                    : {{(DATA_W-LANE_W){1'b0}}, dd_in[LANE_W-1:0]};
        end
    end

    always_comb begin
        cs_on  = busy_q && (t_q >= T_W'(1)) && (t_q < c_q - T_W'(1));
        cs0_n  = !(cs_on && !x_q.alt);
        cs1_n  = !(cs_on && x_q.alt);
        da     = x_q.reg_a;
        dior_n = !(in_pulse && !x_q.write);
        diow_n = !(in_pulse && x_q.write);
        dd_oe  = busy_q && x_q.write && (t_q < a_q);
        dd_out = dd_oe ? x_q.wdata : '0;
        idle   = !busy_q;
        done   = last;
        rdata  = rdata_q;
    end

endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int CNT_W     = 8,
    parameter int SETUP_NS  = 70,
    parameter int ACTIVE_NS = 290,
    parameter int CYCLE_NS  = 600
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CNT_W-1:0]    cfg_setup,
    input  logic [CNT_W-1:0]    cfg_pulse,
    input  logic [CNT_W-1:0]    cfg_cycle,
    input  logic                host_req,
    input  logic                host_write,
    input  logic [HOST_A_W-1:0] host_addr,
    input  logic                host_word,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_done,
    output logic                ata_cs0_n,
    output logic                ata_cs1_n,
    output logic [REG_A_W-1:0]  ata_da,
    output logic                ata_dior_n,
    output logic                ata_diow_n,
    output logic [DATA_W-1:0]   ata_dd_out,
    output logic                ata_dd_oe,
    input  logic [DATA_W-1:0]   ata_dd_in,
    input  logic                ata_iordy
);

    localparam int T_W       = CNT_W + 2;
    localparam int DEF_SETUP = ns_to_cycles(SETUP_NS, CLK_NS);
    localparam int DEF_PULSE = ns_to_cycles(ACTIVE_NS, CLK_NS);
    localparam int DEF_CYCLE = ns_to_cycles(CYCLE_NS, CLK_NS);

    logic [T_W-1:0] eff_setup, eff_active, eff_cycle;
    pio_xfer_t      xfer;
    logic           seq_idle;
    logic           unused_lsb;

    assign unused_lsb = host_addr[0];

    pio_timing_regs #(
        .CNT_W(CNT_W), .DEF_SETUP(DEF_SETUP),
        .DEF_PULSE(DEF_PULSE), .DEF_CYCLE(DEF_CYCLE)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_ok(seq_idle && !host_req),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
        .eff_setup(eff_setup), .eff_active(eff_active), .eff_cycle(eff_cycle)
    );

    pio_addr_map u_map (
        .host_write(host_write), .host_addr_hi(host_addr[HOST_A_W-1:1]),
        .host_word(host_word), .host_wdata(host_wdata), .xfer(xfer)
    );

    pio_cycle_seq #(.T_W(T_W)) u_seq (
        .clk(clk), .rst(rst), .req(host_req), .xfer(xfer),
        .eff_setup(eff_setup), .eff_active(eff_active), .eff_cycle(eff_cycle),
        .iordy(ata_iordy), .dd_in(ata_dd_in),
        .idle(seq_idle), .done(host_done), .rdata(host_rdata),
        .cs0_n(ata_cs0_n), .cs1_n(ata_cs1_n), .da(ata_da),
        .dior_n(ata_dior_n), .diow_n(ata_diow_n),
        .dd_out(ata_dd_out), .dd_oe(ata_dd_oe)
    );

endmodule

// File: rtl/pata_pio_engine_chk.sv
module pata_pio_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_done,
    input logic [15:0] host_rdata,
    input logic        ata_cs0_n,
    input logic        ata_cs1_n,
    input logic        ata_dior_n,
    input logic        ata_diow_n,
    input logic        ata_dd_oe,
    input logic        ata_iordy
);

    a_r6_one_bank: assert property (@(posedge clk) disable iff (rst)
        !(!ata_cs0_n && !ata_cs1_n));

    a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n || !ata_diow_n) |-> (ata_cs0_n != ata_cs1_n));

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!ata_dior_n && !ata_diow_n));

    a_r4_float_on_read: assert property (@(posedge clk) disable iff (rst)
        ata_dd_oe |-> ata_dior_n);

    a_r4_drive_under_write: assert property (@(posedge clk) disable iff (rst)
        !ata_diow_n |-> ata_dd_oe);

    a_r8_hold_read: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n && !ata_iordy) |=> !ata_dior_n);

    a_r8_hold_write: assert property (@(posedge clk) disable iff (rst)
        (!ata_diow_n && !ata_iordy) |=> !ata_diow_n);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);

    a_r2_done_quiet: assert property (@(posedge clk) disable iff (rst)
        host_done |-> (ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n));

    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (ata_dior_n && $past(ata_dior_n)) |-> $stable(host_rdata));

endmodule

bind pata_pio_engine pata_pio_engine_chk u_chk (
    .clk(clk), .rst(rst), .host_done(host_done), .host_rdata(host_rdata),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_oe(ata_dd_oe), .ata_iordy(ata_iordy)
);

// File: tb/pata_pio_engine_bench.sv
module pata_pio_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_setup = '0, cfg_pulse = '0, cfg_cycle = '0;
    logic        host_req = 1'b0, host_write = 1'b0, host_word = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata, ata_dd_out, ata_dd_in;
    logic        host_done, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [2:0]  ata_da;
    logic        ata_iordy = 1'b1;

    int n_chk = 0, n_fail = 0, n_cyc = 0;

    always #10 clk = ~clk;

    function automatic int dev_val(int a);
        return ((8'h50 | a) << 8) | (8'hA0 | a);
    endfunction

    assign ata_dd_in = 16'(dev_val(int'(ata_da)));

    pata_pio_engine u_pata_pio_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
        .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .host_req(host_req),
        .host_write(host_write), .host_addr(host_addr), .host_word(host_word),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_out(ata_dd_out),
        .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_busy, m_t, m_S, m_A, m_C, m_wr, m_alt, m_da, m_word, m_wd, m_rd;
    int m_set, m_pul, m_cyc;

    always @(posedge clk) begin
        n_cyc++;
        if (rst) begin
            m_busy = 0; m_t = 0; m_rd = 0; m_S = 0; m_A = 0; m_C = 0;
            m_wr = 0; m_alt = 0; m_da = 0; m_word = 0; m_wd = 0;
            m_set = 4; m_pul = 15; m_cyc = 30;
        end else if (m_busy == 0) begin
            if (host_req) begin
                m_S    = m_set + 1;
                m_A    = m_S + ((m_pul == 0) ? 1 : m_pul);
                m_C    = (m_cyc < m_A + 2) ? m_A + 2 : m_cyc;
                m_wr   = host_write;
                m_alt  = host_addr[4];
                m_da   = host_addr[3:1];
                m_word = (host_word && m_alt == 0 && m_da == 0) ? 1 : 0;
                m_wd   = m_word ? host_wdata : (host_wdata & 16'h00FF);
                m_busy = 1;
                m_t    = 0;
            end else if (cfg_we) begin
                m_set = cfg_setup; m_pul = cfg_pulse; m_cyc = cfg_cycle;
            end
        end else begin
            if (m_t == m_A - 1 && ata_iordy && m_wr == 0)
                m_rd = m_word ? dev_val(m_da) : (dev_val(m_da) & 8'hFF);
            if (m_t == m_C - 1) m_busy = 0;
            else if (!(m_t >= m_S && m_t < m_A && !ata_iordy)) m_t++;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int pul, csw, oe;
            pul = (m_busy != 0 && m_t >= m_S && m_t < m_A) ? 1 : 0;
            csw = (m_busy != 0 && m_t >= 1 && m_t < m_C - 1) ? 1 : 0;
            oe  = (m_busy != 0 && m_wr != 0 && m_t < m_A) ? 1 : 0;
            chk("R6", "cs0_n", ata_cs0_n, !(csw && !m_alt));
            chk("R3", "cs1_n", ata_cs1_n, !(csw && m_alt));
            chk("R1", "dior_n", ata_dior_n, !(pul && !m_wr));
            chk("R4", "diow_n", ata_diow_n, !(pul && m_wr));
            chk("R4", "dd_oe", ata_dd_oe, oe);
            if (oe != 0) chk("R7", "dd_out", ata_dd_out, m_wd);
            chk("R6", "da", ata_da, m_da);
            chk("R2", "done", host_done, (m_busy != 0 && m_t == m_C - 1) ? 1 : 0);
            chk("R5", "rdata", host_rdata, m_rd);
        end
    end

    // ---------------- directed access with measurement ----------------
    int g_start, g_wid, g_cs, g_done, g_cs0, g_cs1, g_dout;

    task automatic cfg_write(int s, int p, int c);
        cfg_we = 1'b1; cfg_setup = 8'(s); cfg_pulse = 8'(p); cfg_cycle = 8'(c);
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_acc(int wr, int addr, int word, int data,
                          int stall_at, int stall_len, int mid);
        int rem = 0;
        g_start = -1; g_wid = 0; g_cs = 0; g_done = -1; g_cs0 = 0; g_cs1 = 0; g_dout = -1;
        host_req = 1'b1; host_write = wr[0]; host_addr = addr[4:0];
        host_word = word[0]; host_wdata = data[15:0];
        @(negedge clk);
        host_req = 1'b0;
        for (int idx = 0; idx < 2000; idx++) begin
            if (!ata_dior_n || !ata_diow_n) begin
                if (g_start < 0) g_start = idx;
                g_wid++;
            end
            if (!ata_cs0_n) begin g_cs++; g_cs0 = 1; end
            if (!ata_cs1_n) begin g_cs++; g_cs1 = 1; end
            if (ata_dd_oe) g_dout = ata_dd_out;
            if (host_done) begin g_done = idx; break; end
            if (rem > 0) begin
                rem--;
                if (rem == 0) ata_iordy = 1'b1;
            end else if (idx == stall_at && stall_len > 0) begin
                ata_iordy = 1'b0; rem = stall_len;
            end
            if (mid != 0) begin
                if (idx == 2) begin
                    cfg_we = 1'b1; cfg_setup = 8'd9; cfg_pulse = 8'd9; cfg_cycle = 8'd60;
                end
                if (idx == 3) begin cfg_we = 1'b0; host_req = 1'b1; end
                if (idx == 4) host_req = 1'b0;
            end
            @(negedge clk);
        end
        ata_iordy = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: quiet during reset
        chk("R11", "cs0_n rst", ata_cs0_n, 1);
        chk("R11", "cs1_n rst", ata_cs1_n, 1);
        chk("R11", "strobes rst", {ata_dior_n, ata_diow_n}, 3);
        chk("R11", "oe rst", ata_dd_oe, 0);
        chk("R11", "done rst", host_done, 0);
        chk("R11", "rdata rst", host_rdata, 0);
        rst = 1'b0;
        @(negedge clk);

        // R9 defaults, byte read of register 1
        do_acc(0, 5'h02, 0, 0, -1, 0, 0);
        chk("R9", "strobe start", g_start, 5);
        chk("R9", "strobe width", g_wid, 15);
        chk("R9", "cs width", g_cs, 28);
        chk("R9", "done offset", g_done, 29);
        chk("R5", "byte read", host_rdata, 16'h00A1);
        chk("R6", "cs0 used", g_cs0, 1);
        chk("R6", "cs1 unused", g_cs1, 0);

        // R4 write timing equals read timing
        cfg_write(2, 3, 20);
        do_acc(1, 5'h00, 1, 16'hBEEF, -1, 0, 0);
        chk("R4", "write start", g_start, 3);
        chk("R4", "write width", g_wid, 3);
        chk("R3", "cs width", g_cs, 18);
        chk("R2", "done offset", g_done, 19);
        chk("R7", "word write data", g_dout, 16'hBEEF);
        do_acc(0, 5'h00, 0, 0, -1, 0, 0);
        chk("R4", "read start", g_start, 3);
        chk("R2", "read done", g_done, 19);
        chk("R7", "byte read reg0", host_rdata, 16'h00A0);

        // R7 word flag on a non-data register and word read of data register
        do_acc(1, 5'h05, 1, 16'h1234, -1, 0, 0);
        chk("R7", "word to reg2 is byte", g_dout, 16'h0034);
        do_acc(0, 5'h01, 1, 0, -1, 0, 0);
        chk("R7", "word read data reg", host_rdata, 16'h50A0);

        // R2 recovery floor
        cfg_write(2, 3, 5);
        do_acc(0, 5'h02, 0, 0, -1, 0, 0);
        chk("R2", "extended done", g_done, 7);
        chk("R3", "extended cs", g_cs, 6);

        // R12 zero pulse
        cfg_write(0, 0, 0);
        do_acc(1, 5'h04, 0, 16'h00C3, -1, 0, 0);
        chk("R12", "start", g_start, 1);
        chk("R12", "width", g_wid, 1);
        chk("R12", "done", g_done, 3);
        chk("R12", "cs", g_cs, 2);

        // R6 control bank
        cfg_write(2, 3, 20);
        do_acc(0, 5'h1C, 0, 0, -1, 0, 0);
        chk("R6", "cs1 used", g_cs1, 1);
        chk("R6", "cs0 unused", g_cs0, 0);
        chk("R5", "alt read", host_rdata, 16'h00A6);

        // R8 ready stretching
        do_acc(0, 5'h02, 0, 0, 4, 3, 0);
        chk("R8", "stretched width", g_wid, 6);
        chk("R8", "stretched done", g_done, 22);
        chk("R8", "read after stall", host_rdata, 16'h00A1);
        do_acc(1, 5'h06, 0, 16'h0077, 5, 2, 0);
        chk("R8", "write width", g_wid, 5);
        chk("R8", "write done", g_done, 21);

        // R10 config and request during a cycle are ignored
        do_acc(0, 5'h02, 0, 0, -1, 0, 1);
        chk("R10", "busy access done", g_done, 19);
        for (int k = 0; k < 4; k++) begin
            chk("R10", "no extra cycle", {ata_cs0_n, ata_cs1_n, ata_dior_n}, 7);
            @(negedge clk);
        end
        do_acc(0, 5'h02, 0, 0, -1, 0, 0);
        chk("R10", "timing kept start", g_start, 3);
        chk("R10", "timing kept done", g_done, 19);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (n_cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule